// File: doc/BRIEF.md
# Parallel MCU-Style LCD Bus Master

This block lets a host processor talk to a panel that exposes a parallel MCU-style bus. The host writes to a small register set. A write to the command port or the data port places an entry in an eight-deep write queue. A sequencer takes entries off the queue one at a time. It plays each one out on the panel pins as a single bus cycle: chip select asserts, then after a programmable setup time the strobe goes active, and then it returns to rest for a programmable recovery time.

One packed timing word holds separate setup, active and recovery widths for reads and for writes. A bit in the control word chooses between 8080 signalling, which uses separate write and read strobes, and 6800 signalling, which uses a read/write level plus an enable pulse. Another field sets the bus width, and data is masked to that width in both directions.

A data-port write with its read flag set queues a read cycle. The value sampled from the panel pins is kept in a read-data register. A separate register drives the panel's active-low reset pin directly.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset, chip select is high (`lcd_cs_n`=1), the data drivers are off (`lcd_data_oe`=0), the panel reset pin is asserted (`lcd_rst_n`=0), and status bit 20 read at address 0 is 0.
- R2: A host write to address 2 (command port) queues one write cycle with `lcd_dc`=0. A write to address 3 (data port) with bit 24 clear queues one write cycle with `lcd_dc`=1. In both cases, bits [23:0] are held on `lcd_data_out` for the whole cycle.
- R3: Address 1 holds the timing word. Its write fields are: recovery-minus-one in [3:0], active width in [7:4] and setup in [11:8]. A write cycle first holds chip select low with both strobes idle for `setup` cycles, with no setup phase when the field is 0. Next it keeps the strobe active for max(active,1) cycles. It then holds chip select low with the strobe idle for recovery+1 cycles. Chip select is high for at least one cycle between cycles. `lcd_data_oe` is 1 only while chip select is low.
- R4: A data-port write with bit 24 set queues a read cycle. The read fields are: recovery in [19:16], active in [23:20] and setup in [27:24]. The setup phase lasts `setup` cycles, the active phase lasts max(active,1) cycles, and the recovery phase lasts max(recovery,1) cycles. `lcd_data_oe` stays 0 for the whole cycle. `lcd_data_in` is sampled in the last active cycle and can be read back at address 4.
- R5: Control bit 0 selects the bus style. With 0 (8080), `lcd_strb_a` is the active-low write strobe and `lcd_strb_b` is the active-low read strobe. With 1 (6800), `lcd_strb_a` is a read/write level: 1 for a read and 0 for a write, held for the whole cycle and 1 when idle. In that mode `lcd_strb_b` is an enable that is high only in the active phase.
- R6: Control bits [3:1] set the bus width: 0 gives 8 bits, 1 gives 9, 2 gives 16, 3 gives 18, and 4 or above gives 24. Written data and captured read data are masked to that width. Bits [5:4] are a format code that can be stored and read back.
- R7: The queue holds 8 entries and sends them strictly in write order. Status bit 20 at address 0 reads 1 while the queue is full. A command-port or data-port write made while the queue is full is discarded.
- R8: The timing word, the bus style and the width are captured when a cycle starts. Rewriting them during a cycle does not change that cycle.
- R9: Bit 0 of address 5 drives `lcd_rst_n` from the clock edge that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after `host_rd` |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_dc | output | 1 | Data/command select, 0 for command and 1 for data |
| lcd_strb_a | output | 1 | Write strobe in 8080 style; read/write level in 6800 style |
| lcd_strb_b | output | 1 | Read strobe in 8080 style; enable in 6800 style |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_data_out | output | 24 | Panel data driven out |
| lcd_data_oe | output | 1 | Output enable for the panel data lines |
| lcd_data_in | input | 24 | Panel data sampled during reads |

## Verification
A queue pointer that slips shows up at the pins as entries that are repeated, lost or out of order, and status bit 20 goes wrong within the same burst of writes. A phase counter that loads the wrong value stretches or shortens a phase by whole cycles. That shows in the first bus cycle after the timing word changes. A capture made on the wrong edge, or a stale mode or width latch, appears in the first read-back or in strobe levels that are wrong for the whole cycle. Every cycle is measured from the pins, cycle by cycle, and compared against lengths derived from the timing fields.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  localparam int LCD_DW = 24;

  typedef struct packed {
    logic              is_data;
    logic              is_read;
    logic [LCD_DW-1:0] data;
  } lcd_entry_t;

  localparam int ENTRY_W = LCD_DW + 2;

  function automatic logic [LCD_DW-1:0] width_mask(input logic [2:0] code);
    case (code)
      3'd0:    width_mask = LCD_DW'(24'h0000FF);
      3'd1:    width_mask = LCD_DW'(24'h0001FF);
      3'd2:    width_mask = LCD_DW'(24'h00FFFF);
      3'd3:    width_mask = LCD_DW'(24'h03FFFF);
      default: width_mask = LCD_DW'(24'hFFFFFF);
    endcase
  endfunction
endpackage

// File: rtl/lcd_wfifo.sv
module lcd_wfifo #(
  parameter int W     = 26,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] cnt;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == LW'(DEPTH));
  assign level = cnt;
endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_bus_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ent_valid,
  input  lcd_entry_t        ent,
  output logic              ent_pop,
  input  logic [31:0]       timing,
  input  logic              mode_6800,
  input  logic [2:0]        width_code,
  output logic              cs_n,
  output logic              dc,
  output logic              strb_a,
  output logic              strb_b,
  output logic [LCD_DW-1:0] dout,
  output logic              oe,
  input  logic [LCD_DW-1:0] din,
  output logic [LCD_DW-1:0] rd_data
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_REC} state_t;

  state_t            state;
  logic [TW-1:0]     cnt, low_m1_q, high_m1_q;
  logic              rd_q, m6800_q, dc_q;
  logic [LCD_DW-1:0] data_q, mask_q;

  logic [TW-1:0] css, low_raw, high_raw, low_m1, high_m1;

  always_comb begin
    if (ent.is_read) begin
      css      = timing[24 +: TW];
      low_raw  = timing[20 +: TW];
      high_raw = timing[16 +: TW];
      high_m1  = (high_raw == '0) ? '0 : high_raw - 1'b1;
    end else begin
      css      = timing[8 +: TW];
      low_raw  = timing[4 +: TW];
      high_raw = timing[0 +: TW];
      high_m1  = high_raw;
    end
    low_m1 = (low_raw == '0) ? '0 : low_raw - 1'b1;
  end

  assign ent_pop = (state == S_IDLE) && ent_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      low_m1_q  <= '0;
      high_m1_q <= '0;
      rd_q      <= 1'b0;
      m6800_q   <= 1'b0;
      dc_q      <= 1'b1;
      data_q    <= '0;
      mask_q    <= '0;
      rd_data   <= '0;
    end else begin
      case (state)
        S_IDLE: if (ent_valid) begin
          rd_q      <= ent.is_read;
          dc_q      <= ent.is_data;
          m6800_q   <= mode_6800;
          mask_q    <= width_mask(width_code);
          data_q    <= ent.data & width_mask(width_code);
          low_m1_q  <= low_m1;
          high_m1_q <= high_m1;
          if (css != '0) begin
            state <= S_SETUP;
            cnt   <= css - 1'b1;
          end else begin
            state <= S_ACT;
            cnt   <= low_m1;
          end
        end
        S_SETUP: if (cnt == '0) begin
          state <= S_ACT;
          cnt   <= low_m1_q;
        end else cnt <= cnt - 1'b1;
        S_ACT: if (cnt == '0) begin
          state <= S_REC;
          cnt   <= high_m1_q;
          if (rd_q) rd_data <= din & mask_q;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) state <= S_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  logic busy, act;
  assign busy = (state != S_IDLE);
  assign act  = (state == S_ACT);

  always_comb begin
    cs_n = !busy;
    dc   = dc_q;
    oe   = busy && !rd_q;
    dout = oe ? data_q : '0;
    if (m6800_q) begin
      strb_a = busy ? rd_q : 1'b1;
      strb_b = act;
    end else begin
      strb_a = !(act && !rd_q);
      strb_b = !(act && rd_q);
    end
  end
endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lcd_bus_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TW         = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              lcd_cs_n,
  output logic              lcd_dc,
  output logic              lcd_strb_a,
  output logic              lcd_strb_b,
  output logic              lcd_rst_n,
  output logic [LCD_DW-1:0] lcd_data_out,
  output logic              lcd_data_oe,
  input  logic [LCD_DW-1:0] lcd_data_in
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TIME = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_RDAT = 3'd4;
  localparam logic [2:0] A_PRST = 3'd5;
  localparam int FULL_BIT = 20;
  localparam int RD_FLAG  = 24;
  localparam int LW       = $clog2(FIFO_DEPTH+1);

  logic [5:0]        ctrl_q;
  logic [31:0]       timing_q;
  logic              prst_q;
  lcd_entry_t        push_ent, head_ent;
  logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [LW-1:0]     fifo_level;
  logic [LCD_DW-1:0] rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      timing_q <= '0;
      prst_q   <= 1'b0;
    end else if (host_wr) begin
      case (host_addr)
        A_CTRL:  ctrl_q   <= host_wdata[5:0];
        A_TIME:  timing_q <= host_wdata;
        A_PRST:  prst_q   <= host_wdata[0];
        default: ;
      endcase
    end
  end

  assign fifo_push        = host_wr && (host_addr == A_CMD || host_addr == A_DATA);
  assign push_ent.is_data = (host_addr == A_DATA);
  assign push_ent.is_read = (host_addr == A_DATA) && host_wdata[RD_FLAG];
  assign push_ent.data    = host_wdata[LCD_DW-1:0];

  lcd_wfifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   (push_ent),
    .pop   (fifo_pop),
    .dout  (head_ent),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_level)
  );

  lcd_bus_seq #(.TW(TW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ent_valid  (!fifo_empty),
    .ent        (head_ent),
    .ent_pop    (fifo_pop),
    .timing     (timing_q),
    .mode_6800  (ctrl_q[0]),
    .width_code (ctrl_q[3:1]),
    .cs_n       (lcd_cs_n),
    .dc         (lcd_dc),
    .strb_a     (lcd_strb_a),
    .strb_b     (lcd_strb_b),
    .dout       (lcd_data_out),
    .oe         (lcd_data_oe),
    .din        (lcd_data_in),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) begin
      host_rdata <= '0;
      case (host_addr)
        A_CTRL: begin
          host_rdata[5:0]      <= ctrl_q;
          host_rdata[FULL_BIT] <= fifo_full;
        end
        A_TIME:  host_rdata <= timing_q;
        A_RDAT:  host_rdata[LCD_DW-1:0] <= rd_data;
        A_PRST:  host_rdata[0] <= prst_q;
        default: ;
      endcase
    end
  end

  assign lcd_rst_n = prst_q;
endmodule

// File: rtl/lcd_bus_master_chk.sv
module lcd_bus_master_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          oe,
  input logic [23:0]   dout,
  input logic          dc,
  input logic          host_wr,
  input logic [2:0]    host_addr,
  input logic [31:0]   host_wdata,
  input logic          rst_n,
  input logic [LW-1:0] lvl
);
  assert_oe_in_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !oe);

  assert_stable_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> ($stable(dout) && $stable(dc)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    lvl <= LW'(DEPTH));

  assert_reset_pin_R9: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd5) |=> (rst_n == $past(host_wdata[0])));
endmodule

bind lcd_bus_master lcd_bus_master_chk #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (lcd_cs_n),
  .oe         (lcd_data_oe),
  .dout       (lcd_data_out),
  .dc         (lcd_dc),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .rst_n      (lcd_rst_n),
  .lvl        (fifo_level)
);

// File: tb/sim_lcd_bus_master.sv
module sim_lcd_bus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        lcd_cs_n, lcd_dc, lcd_strb_a, lcd_strb_b, lcd_rst_n, lcd_data_oe;
  logic [23:0] lcd_data_out;
  logic [23:0] lcd_data_in = 24'hA5C3F1;

  always #10 clk = ~clk;

  lcd_bus_master u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc), .lcd_strb_a(lcd_strb_a),
    .lcd_strb_b(lcd_strb_b), .lcd_rst_n(lcd_rst_n), .lcd_data_out(lcd_data_out),
    .lcd_data_oe(lcd_data_oe), .lcd_data_in(lcd_data_in)
  );

  int total = 0, bad = 0;
  bit m6800 = 0;

  // per-bus-cycle records measured at the pins
  int          n_cyc = 0;
  bit          in_cyc = 0;
  int          r_setup[64], r_act[64], r_rec[64];
  logic [23:0] r_data[64];
  logic        r_dc[64], r_rw[64], r_oe[64], r_rw_bad[64];

  always @(negedge clk) begin
    if (!rst && n_cyc < 64) begin
      if (!lcd_cs_n) begin
        bit act;
        act = m6800 ? lcd_strb_b : (!lcd_strb_a || !lcd_strb_b);
        if (!in_cyc) begin
          in_cyc = 1;
          r_setup[n_cyc] = 0; r_act[n_cyc] = 0; r_rec[n_cyc] = 0;
          r_oe[n_cyc] = lcd_data_oe; r_rw[n_cyc] = lcd_strb_a;
          r_rw_bad[n_cyc] = 0; r_dc[n_cyc] = lcd_dc; r_data[n_cyc] = lcd_data_out;
        end
        if (lcd_strb_a != r_rw[n_cyc]) r_rw_bad[n_cyc] = 1;
        if (act) r_act[n_cyc]++;
        else if (r_act[n_cyc] == 0) r_setup[n_cyc]++;
        else r_rec[n_cyc]++;
        if (act && !m6800) r_rw[n_cyc] = lcd_strb_b;  // 0 = read strobe used
      end else if (in_cyc) begin
        in_cyc = 0;
        n_cyc++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [31:0] tw(input int rc, input int rl, input int rh,
                                     input int wc, input int wl, input int wh);
    return {4'h0, 4'(rc), 4'(rl), 4'(rh), 4'h0, 4'(wc), 4'(wl), 4'(wh)};
  endfunction

  task automatic wait_n(input int target, input string req);
    int guard = 0;
    while (n_cyc < target && guard < 5000) begin
      @(negedge clk); guard++;
    end
    if (guard >= 5000) chk({req, " bus cycle never finished"}, n_cyc, target);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 cs_n", lcd_cs_n, 1);
    chk("R1 oe", lcd_data_oe, 0);
    chk("R1 rst_n", lcd_rst_n, 0);
    hread(3'd0, d);
    chk("R1 status full", d[20], 0);
  endtask

  task automatic t_rst_reg;
    hwrite(3'd5, 1); chk("R9 release", lcd_rst_n, 1);
    hwrite(3'd5, 0); chk("R9 assert", lcd_rst_n, 0);
    hwrite(3'd5, 1); chk("R9 release again", lcd_rst_n, 1);
  endtask

  task automatic t_write8080;
    int b = n_cyc;
    m6800 = 0;
    hwrite(3'd0, 32'h8);
    hwrite(3'd1, tw(0, 0, 0, 2, 3, 1));
    hwrite(3'd2, 32'h123456);
    hwrite(3'd3, 32'hABCDEF);
    wait_n(b + 2, "R2");
    chk("R2 cmd dc", r_dc[b], 0);
    chk("R2 cmd data", r_data[b], 24'h123456);
    chk("R2 data dc", r_dc[b+1], 1);
    chk("R2 data value", r_data[b+1], 24'hABCDEF);
    chk("R3 setup", r_setup[b], 2);
    chk("R3 active", r_act[b], 3);
    chk("R3 recovery", r_rec[b], 2);
    chk("R3 oe on write", r_oe[b], 1);
    chk("R5 8080 write strobe used", r_rw[b], 1);
  endtask

  task automatic t_zero;
    int b = n_cyc;
    hwrite(3'd1, tw(0, 0, 0, 0, 0, 0));
    hwrite(3'd2, 32'h55);
    wait_n(b + 1, "R3");
    chk("R3 zero setup", r_setup[b], 0);
    chk("R3 zero active", r_act[b], 1);
    chk("R3 zero recovery", r_rec[b], 1);
  endtask

  task automatic t_read;
    int b = n_cyc;
    logic [31:0] d;
    hwrite(3'd0, 32'h4);
    hwrite(3'd1, tw(1, 2, 3, 0, 0, 0));
    hwrite(3'd3, 32'h0100_0000);
    wait_n(b + 1, "R4");
    chk("R4 setup", r_setup[b], 1);
    chk("R4 active", r_act[b], 2);
    chk("R4 recovery", r_rec[b], 3);
    chk("R4 oe off", r_oe[b], 0);
    chk("R4 read strobe used", r_rw[b], 0);
    chk("R4 dc data", r_dc[b], 1);
    hread(3'd4, d);
    chk("R4 R6 captured 16-bit", d, 32'h00C3F1);
  endtask

  task automatic t_width;
    int b = n_cyc;
    hwrite(3'd1, tw(0, 0, 0, 0, 0, 0));
    hwrite(3'd0, 32'h00); hwrite(3'd2, 32'h1234);
    wait_n(b + 1, "R6");
    hwrite(3'd0, 32'h12); hwrite(3'd2, 32'h3FF);
    wait_n(b + 2, "R6");
    hwrite(3'd0, 32'h16); hwrite(3'd2, 32'hFFFFFF);
    wait_n(b + 3, "R6");
    chk("R6 width 8", r_data[b], 24'h34);
    chk("R6 width 9", r_data[b+1], 24'h1FF);
    chk("R6 width 18", r_data[b+2], 24'h3FFFF);
  endtask

  task automatic t_6800;
    int b = n_cyc;
    m6800 = 1;
    hwrite(3'd0, 32'h9);
    hwrite(3'd1, tw(0, 3, 1, 1, 2, 0));
    hwrite(3'd2, 32'h77);
    wait_n(b + 1, "R5");
    hwrite(3'd3, 32'h0100_0000);
    wait_n(b + 2, "R5");
    chk("R5 6800 write rw level", r_rw[b], 0);
    chk("R5 6800 write rw stable", r_rw_bad[b], 0);
    chk("R5 6800 enable width", r_act[b], 2);
    chk("R5 6800 read rw level", r_rw[b+1], 1);
    chk("R5 6800 read rw stable", r_rw_bad[b+1], 0);
    chk("R5 6800 read enable width", r_act[b+1], 3);
    chk("R5 idle rw", lcd_strb_a, 1);
    chk("R5 idle enable", lcd_strb_b, 0);
    m6800 = 0;
    hwrite(3'd0, 32'h8);
  endtask

  task automatic t_fifo;
    int b = n_cyc;
    logic [31:0] d;
    hwrite(3'd1, tw(0, 0, 0, 15, 15, 15));
    for (int i = 0; i < 10; i++) hwrite(3'd3, 32'(i + 1));
    hread(3'd0, d);
    chk("R7 full bit set", d[20], 1);
    wait_n(b + 9, "R7");
    repeat (100) @(negedge clk);
    chk("R7 full write discarded", n_cyc, b + 9);
    for (int i = 0; i < 9; i++) chk("R7 order", r_data[b+i], 24'(i + 1));
    hread(3'd0, d);
    chk("R7 full bit clear", d[20], 0);
  endtask

  task automatic t_timing_change;
    int b = n_cyc;
    hwrite(3'd1, tw(0, 0, 0, 15, 15, 15));
    hwrite(3'd2, 32'h11);
    repeat (8) @(negedge clk);
    hwrite(3'd1, tw(0, 0, 0, 1, 2, 0));
    hwrite(3'd0, 32'h0);
    hwrite(3'd2, 32'h22);
    wait_n(b + 2, "R8");
    chk("R8 old setup", r_setup[b], 15);
    chk("R8 old active", r_act[b], 15);
    chk("R8 old recovery", r_rec[b], 16);
    chk("R8 old width kept", r_data[b], 24'h11);
    chk("R8 new setup", r_setup[b+1], 1);
    chk("R8 new active", r_act[b+1], 2);
    chk("R8 new recovery", r_rec[b+1], 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rst_reg();
    t_write8080();
    t_zero();
    t_read();
    t_width();
    t_6800();
    t_fifo();
    t_timing_change();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule